// File: doc/BRIEF.md
# Periodic Reload Down-Counter with Register Access

This block is a 16-bit down-counter that software controls through a small 32-bit register bus. Three word registers sit in a 256-byte window: a control word, a reload value and a read-only view of the live count. The counter only moves in cycles where `tick_en` is high, so the surrounding logic sets the count rate. Typically that rate is a 1 MHz strobe.

Software writes a reload value, which is copied straight into the counter. It then sets the enable bit in the control word to start counting. The counter steps down once per tick, and on the tick after it reaches zero it starts again from the reload value. Clearing the enable bit does not stop a running counter. Only the reset bit in the control word, or the hardware reset, returns the block to idle with all registers cleared.

The sequencing core is a two-state machine. State IDLE holds the count. State RUN counts on every tick. Transition START goes from IDLE to RUN when a control word with the enable bit set and the reset bit clear is written. Transition HALT goes from RUN to IDLE on a control write with the reset bit set. The hardware reset forces IDLE from either state.

Top module: `reload_timer_top`

## Requirements
- R1: After hardware reset the control, reload and count registers all read 0, and the counter does not move on ticks. Asserting reset while the counter is running has the same effect.
- R2: A control write (offset 0x00) with bit 31 clear stores the full 32-bit word, and a later read returns it unchanged.
- R3: A reload write (offset 0x04) stores bits 15:0, and reads return them with bits 31:16 zero. The same value is loaded into the live count on the next clock edge.
- R4: A read of the count register (offset 0x08) returns the live count in bits 15:0 with bits 31:16 zero. Writes to offset 0x08 change nothing.
- R5: In RUN, each cycle with `tick_en` high decrements a non-zero count by one. Cycles without `tick_en` leave the count unchanged.
- R6: In RUN, a tick that arrives while the count is zero loads the reload value. With a reload of zero the count stays at zero.
- R7: In IDLE, ticks do not change the count.
- R8: A control write with bit 0 set and bit 31 clear takes the block from IDLE to RUN (START).
- R9: A control write with bit 0 clear and bit 31 clear does not stop a running counter.
- R10: A control write with bit 31 set clears the control, reload and count registers and moves the block to IDLE (HALT). The written word is not stored.
- R11: Any offset other than 0x00, 0x04 and 0x08, including unaligned ones, reads as 0, and writes to it change no register.
- R12: A reload write while running replaces the count at once. When a tick arrives in the same cycle as the write, the written value wins over the decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe, one decrement per high cycle |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_we | input | 1 | Write strobe for one whole word |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, 0 when `bus_re` is low |

## Verification
The hardest case to reach from the ports is a reload write that lands in the same cycle as a tick while the counter is running. The write must win over the decrement. The stimulus reaches it by first starting the counter and ticking it part-way down. It then raises `tick_en` and the reload write strobe on the same falling edge, so both are seen at one rising edge. A second hard case is a control write with enable clear during RUN. It can only be told apart from a stop by ticking afterwards and reading the count back.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_reload;
        logic soft_rst;
        logic start;
    } bus_cmd_t;

endpackage

// File: rtl/rtmr_decode.sv
module rtmr_decode
    import rtmr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned OFF_CTRL   = 'h00,
    parameter int unsigned OFF_RELOAD = 'h04,
    parameter int unsigned OFF_COUNT  = 'h08
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wr_rst_bit,
    input  logic              wr_en_bit,
    output reg_sel_e          sel,
    output bus_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);

    always_comb begin
        if (addr == A_CTRL) begin
            sel = SEL_CTRL;
        end else if (addr == A_RELOAD) begin
            sel = SEL_RELOAD;
        end else if (addr == A_COUNT) begin
            sel = SEL_COUNT;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        cmd           = '0;
        cmd.soft_rst  = we && (sel == SEL_CTRL) && wr_rst_bit;
        cmd.wr_ctrl   = we && (sel == SEL_CTRL) && !wr_rst_bit;
        cmd.start     = cmd.wr_ctrl && wr_en_bit;
        cmd.wr_reload = we && (sel == SEL_RELOAD);
    end

endmodule

// File: rtl/rtmr_regfile.sv
module rtmr_regfile
    import rtmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cmd_t          cmd,
    input  reg_sel_e          sel,
    input  logic              re,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - CNT_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cmd.soft_rst) begin
            ctrl_q <= '0;
        end else if (cmd.wr_ctrl) begin
            ctrl_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (cmd.soft_rst) begin
            reload_q <= '0;
        end else if (cmd.wr_reload) begin
            reload_q <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            unique case (sel)
                SEL_CTRL:   rdata = ctrl_q;
                SEL_RELOAD: rdata = {{PAD_W{1'b0}}, reload_q};
                SEL_COUNT:  rdata = {{PAD_W{1'b0}}, count};
                SEL_NONE:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter
    import rtmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  bus_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_q,
    output logic             running,
    output logic [CNT_W-1:0] count_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e state_q;
    tmr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START (IDLE->RUN), HALT (RUN->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cmd.soft_rst && cmd.start) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cmd.soft_rst) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        running = (state_q == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cmd.soft_rst) begin
            count_q <= '0;
        end else if (cmd.wr_reload) begin
            count_q <= load_val;
        end else if (running && tick_en) begin
            if (count_q == '0) begin
                count_q <= reload_q;
            end else begin
                count_q <= count_q - ONE;
            end
        end
    end

endmodule

// File: rtl/reload_timer_top.sv
module reload_timer_top
    import rtmr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned RST_BIT    = 31,
    parameter int unsigned EN_BIT     = 0,
    parameter int unsigned OFF_CTRL   = 'h00,
    parameter int unsigned OFF_RELOAD = 'h04,
    parameter int unsigned OFF_COUNT  = 'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata
);

    reg_sel_e          sel;
    bus_cmd_t          cmd;
    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  count_q;
    logic              running;

    rtmr_decode #(
        .ADDR_W    (ADDR_W),
        .OFF_CTRL  (OFF_CTRL),
        .OFF_RELOAD(OFF_RELOAD),
        .OFF_COUNT (OFF_COUNT)
    ) u_decode (
        .addr      (bus_addr),
        .we        (bus_we),
        .wr_rst_bit(bus_wdata[RST_BIT]),
        .wr_en_bit (bus_wdata[EN_BIT]),
        .sel       (sel),
        .cmd       (cmd)
    );

    rtmr_regfile #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .sel     (sel),
        .re      (bus_re),
        .wdata   (bus_wdata),
        .count   (count_q),
        .ctrl_q  (ctrl_q),
        .reload_q(reload_q),
        .rdata   (bus_rdata)
    );

    rtmr_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cmd     (cmd),
        .load_val(bus_wdata[CNT_W-1:0]),
        .reload_q(reload_q),
        .running (running),
        .count_q (count_q)
    );

endmodule

// File: rtl/rtmr_checker.sv
module rtmr_checker #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned RST_BIT    = 31,
    parameter int unsigned EN_BIT     = 0,
    parameter int unsigned OFF_CTRL   = 'h00,
    parameter int unsigned OFF_RELOAD = 'h04,
    parameter int unsigned OFF_COUNT  = 'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              running,
    input logic [CNT_W-1:0]  count,
    input logic [DATA_W-1:0] ctrl,
    input logic [CNT_W-1:0]  reload
);

    logic hit_ctrl, hit_reload, hit_count;
    assign hit_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
    assign hit_reload = (bus_addr == ADDR_W'(OFF_RELOAD));
    assign hit_count  = (bus_addr == ADDR_W'(OFF_COUNT));

    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_reload) |=> (count == $past(bus_wdata[CNT_W-1:0]) &&
                                     reload == $past(bus_wdata[CNT_W-1:0]))); // R3

    AST_COUNT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && hit_count) |-> (bus_rdata[DATA_W-1:CNT_W] == '0)); // R4

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && !bus_we && count != '0)
        |=> (count == ($past(count) - CNT_W'(1)))); // R5

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && !bus_we && count == '0) |=> (count == $past(reload))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !bus_we) |=> $stable(count)); // R7

    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_ctrl && !bus_wdata[RST_BIT] && bus_wdata[EN_BIT]) |=> running); // R8

    AST_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(bus_we && hit_ctrl && bus_wdata[RST_BIT])) |=> running); // R9

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_ctrl && bus_wdata[RST_BIT])
        |=> (!running && ctrl == '0 && reload == '0 && count == '0)); // R10

endmodule

bind reload_timer_top rtmr_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .RST_BIT   (RST_BIT),
    .EN_BIT    (EN_BIT),
    .OFF_CTRL  (OFF_CTRL),
    .OFF_RELOAD(OFF_RELOAD),
    .OFF_COUNT (OFF_COUNT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_re   (bus_re),
    .bus_rdata(bus_rdata),
    .running  (running),
    .count    (count_q),
    .ctrl     (ctrl_q),
    .reload   (reload_q)
);

// File: tb/sim_reload_timer_top.sv
module sim_reload_timer_top;

    localparam int PERIOD = 10;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam int NVEC = 35;

    // {req, op, addr, data, expected}
    localparam logic [81:0] VEC [NVEC] = '{
        {8'd1,  OP_RD, 8'h00, 32'h0,        32'h0},        // R1
        {8'd1,  OP_RD, 8'h04, 32'h0,        32'h0},
        {8'd1,  OP_RD, 8'h08, 32'h0,        32'h0},
        {8'd3,  OP_WR, 8'h04, 32'hABCD0005, 32'h0},        // R3
        {8'd3,  OP_RD, 8'h04, 32'h0,        32'h5},
        {8'd3,  OP_RD, 8'h08, 32'h0,        32'h5},
        {8'd7,  OP_TK, 8'h00, 32'd3,        32'h0},        // R7
        {8'd7,  OP_RD, 8'h08, 32'h0,        32'h5},
        {8'd8,  OP_WR, 8'h00, 32'h12345601, 32'h0},        // R8
        {8'd2,  OP_RD, 8'h00, 32'h0,        32'h12345601}, // R2
        {8'd5,  OP_TK, 8'h00, 32'd2,        32'h0},        // R5
        {8'd5,  OP_RD, 8'h08, 32'h0,        32'h3},
        {8'd5,  OP_TK, 8'h00, 32'd3,        32'h0},
        {8'd5,  OP_RD, 8'h08, 32'h0,        32'h0},
        {8'd6,  OP_TK, 8'h00, 32'd1,        32'h0},        // R6
        {8'd6,  OP_RD, 8'h08, 32'h0,        32'h5},
        {8'd9,  OP_WR, 8'h00, 32'h0,        32'h0},        // R9
        {8'd9,  OP_TK, 8'h00, 32'd2,        32'h0},
        {8'd9,  OP_RD, 8'h08, 32'h0,        32'h3},
        {8'd4,  OP_WR, 8'h08, 32'h0000FFFF, 32'h0},        // R4
        {8'd4,  OP_RD, 8'h08, 32'h0,        32'h3},
        {8'd11, OP_WR, 8'h0C, 32'hDEADBEEF, 32'h0},        // R11
        {8'd11, OP_WR, 8'h02, 32'hFFFFFFFF, 32'h0},
        {8'd11, OP_RD, 8'h0C, 32'h0,        32'h0},
        {8'd11, OP_RD, 8'h00, 32'h0,        32'h0},
        {8'd11, OP_RD, 8'h04, 32'h0,        32'h5},
        {8'd11, OP_RD, 8'h08, 32'h0,        32'h3},
        {8'd12, OP_WR, 8'h04, 32'h00000009, 32'h0},        // R12
        {8'd12, OP_RD, 8'h08, 32'h0,        32'h9},
        {8'd10, OP_WR, 8'h00, 32'h80000001, 32'h0},        // R10
        {8'd10, OP_RD, 8'h00, 32'h0,        32'h0},
        {8'd10, OP_RD, 8'h04, 32'h0,        32'h0},
        {8'd10, OP_RD, 8'h08, 32'h0,        32'h0},
        {8'd10, OP_TK, 8'h00, 32'd3,        32'h0},
        {8'd10, OP_RD, 8'h08, 32'h0,        32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    reload_timer_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input int req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        bus_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [81:0] v;
            v = VEC[i];
            unique case (v[73:72])
                OP_WR: wr(v[71:64], v[63:32]);
                OP_RD: rd_chk(int'(v[81:74]), v[71:64], v[31:0]);
                default: ticks(int'(v[63:32]));
            endcase
        end

        // R6: zero reload keeps the count at zero while running
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h1);
        ticks(4);
        rd_chk(6, 8'h08, 32'h0);
        wr(8'h00, 32'h80000000);

        // R12: reload write and tick in the same cycle, write wins
        wr(8'h04, 32'd20);
        wr(8'h00, 32'h1);
        ticks(5);
        rd_chk(5, 8'h08, 32'd15);
        @(negedge clk);
        tick_en = 1'b1; bus_addr = 8'h04; bus_wdata = 32'd7; bus_we = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        rd_chk(12, 8'h08, 32'd7);
        ticks(1);
        rd_chk(5, 8'h08, 32'd6);

        // R1: hardware reset while running
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(1, 8'h00, 32'h0);
        rd_chk(1, 8'h04, 32'h0);
        rd_chk(1, 8'h08, 32'h0);
        wr(8'h04, 32'd2);
        ticks(3);
        rd_chk(1, 8'h08, 32'd2);

        // R8 and R6: restart after reset, wrap 2->1->0->2
        wr(8'h00, 32'h1);
        ticks(3);
        rd_chk(6, 8'h08, 32'd2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule